// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order 32-bit processor built as five stages: fetch, decode, execute, memory and write-back. Each instruction moves one stage per clock, so once the pipeline is full a new instruction finishes every cycle. The block runs register-to-register arithmetic, word loads, word stores and a branch on equal registers. Instruction storage and data storage are two separate arrays inside the block. Fetch and data access therefore never compete for one memory.

All control bits are decoded once, in decode. They then travel with their instruction through the stage registers, together with its destination register number. The register file is write-first: a value written back in a cycle is already visible to the instruction being decoded in that cycle. Forwarding and load-use stalling are handled by separate companion blocks. This core alone therefore expects a producer and its consumer to be at least three instructions apart. A taken branch is resolved in the memory stage and discards the three younger instructions behind it.

A test environment fills both arrays through two preload ports, releases reset, and watches the write-back and store outputs.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted and right after it, the PC is 0, every stage holds a bubble and the register file reads zero. The first instruction appears at the write-back outputs after the fourth rising edge following reset release.
- R2: Instruction fields are: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, function code in 5:0, and a signed 16-bit immediate in 15:0. Opcode 0x00 is register arithmetic, 0x23 is load word, 0x2B is store word and 0x04 is branch-if-equal.
- R3: Opcode 0x00 writes rd with an operation picked by the function code: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (giving 1 or 0).
- R4: A load or store uses the address rs plus the sign-extended immediate. The data array word index is address bits DMEM_AW+1:2. A load writes rt. A store presents its address and the rt value on the store outputs in the memory stage.
- R5: Branch-if-equal with rs equal to rt jumps to PC+4 plus the immediate shifted left by 2. The three younger instructions are discarded, and none of them writes a register or memory. An untaken branch has no effect.
- R6: Register 0 always reads as zero. A write aimed at it is dropped and does not show on the write-back outputs.
- R7: An instruction in decode reads the value that the write-back stage writes in that same cycle, so a consumer three instructions after its producer gets the new value.
- R8: Write-back goes to the destination register of the retiring instruction: rd for arithmetic and rt for loads.
- R9: Independent instructions issued back to back retire one per cycle on consecutive cycles.
- R10: Any other opcode, and opcode 0x00 with any other function code, behaves as a no-op: no register write and no store.
- R11: A load in the memory stage and the fetch in the same cycle both complete, because the instruction array and the data array are separate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Write enable for the instruction array preload |
| prog_addr | input | IMEM_AW | Word index for the instruction preload |
| prog_data | input | 32 | Instruction word to preload |
| data_we | input | 1 | Write enable for the data array preload (wins over a store) |
| data_addr | input | DMEM_AW | Word index for the data preload |
| data_wdata | input | 32 | Data word to preload |
| pc_o | output | 32 | Current fetch address |
| retire_we | output | 1 | Write-back of a nonzero register this cycle |
| retire_reg | output | 5 | Register being written |
| retire_val | output | 32 | Value being written |
| store_we | output | 1 | Store in the memory stage this cycle |
| store_addr | output | 32 | Byte address of that store |
| store_val | output | 32 | Data of that store |

## Verification
Random programs mix all four instruction kinds, rd=0 writes and unused encodings. Each pair of instructions is spaced three words apart, so every dependency hits the same-cycle write/read path. Branch register pairs are drawn from a small set so that both taken and untaken cases occur. The retire and store streams are compared in order against an instruction-level model: a skipped branch shadow or a wrong destination shows up as an extra or missing event. A directed program of back-to-back independent loads pins down the first-retire cycle and the one-per-cycle rate. Its tail checks that a write to register 0 is not seen by a later read and that unused encodings retire nothing.

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core #(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [31:0]        prog_data,
  input  logic               data_we,
  input  logic [DMEM_AW-1:0] data_addr,
  input  logic [31:0]        data_wdata,
  output logic [31:0]        pc_o,
  output logic               retire_we,
  output logic [4:0]         retire_reg,
  output logic [31:0]        retire_val,
  output logic               store_we,
  output logic [31:0]        store_addr,
  output logic [31:0]        store_val
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;
  localparam logic [5:0] OP_ALU = 6'h00, OP_LOAD = 6'h23, OP_STORE = 6'h2b, OP_BEQ = 6'h04;
  localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24, FN_OR = 6'h25, FN_SLT = 6'h2a;
  // control vector: regdst, aluop[1:0], alusrc | branch, memrd, memwr | regwr, mem2reg
  localparam int C_REGDST = 8, C_ALUSRC = 5, C_BR = 4, C_MRD = 3, C_MWR = 2, C_RW = 1, C_M2R = 0;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  logic [31:0] pc, fetch_word;
  logic [31:0] ifid_ir, ifid_pc4;
  logic [8:0]  idex_c;
  logic [31:0] idex_a, idex_b, idex_imm, idex_pc4;
  logic [4:0]  idex_rt, idex_rd;
  logic [5:0]  idex_fn;
  logic [4:0]  exmem_c;
  logic        exmem_zero;
  logic [31:0] exmem_tgt, exmem_alu, exmem_sd;
  logic [4:0]  exmem_dst;
  logic [1:0]  memwb_c;
  logic [31:0] memwb_ld, memwb_alu;
  logic [4:0]  memwb_dst;

  // fetch
  always_ff @(posedge clk) if (prog_we) imem[prog_addr] <= prog_data;
  assign fetch_word = imem[pc[IMEM_AW+1:2]];

  // decode
  logic [5:0]  id_op, id_fn;
  logic [4:0]  id_rs, id_rt, id_rd;
  logic [31:0] id_imm, id_a, id_b;
  logic [8:0]  id_c;
  assign id_op  = ifid_ir[31:26];
  assign id_rs  = ifid_ir[25:21];
  assign id_rt  = ifid_ir[20:16];
  assign id_rd  = ifid_ir[15:11];
  assign id_fn  = ifid_ir[5:0];
  assign id_imm = {{16{ifid_ir[15]}}, ifid_ir[15:0]};

  always_comb begin
    id_c = '0;
    case (id_op)
      OP_ALU:   if (id_fn inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT}) id_c = 9'b1_10_0_000_10;
      OP_LOAD:  id_c = 9'b0_00_1_010_11;
      OP_STORE: id_c = 9'b0_00_1_001_00;
      OP_BEQ:   id_c = 9'b0_01_0_100_00;
      default:  id_c = '0;
    endcase
  end

  // write-back and write-first register file
  logic        wb_we;
  logic [31:0] wb_val;
  assign wb_we  = memwb_c[C_RW] && (memwb_dst != 5'd0);
  assign wb_val = memwb_c[C_M2R] ? memwb_ld : memwb_alu;
  assign id_a = (id_rs == 5'd0) ? 32'd0 : (wb_we && memwb_dst == id_rs) ? wb_val : rf[id_rs];
  assign id_b = (id_rt == 5'd0) ? 32'd0 : (wb_we && memwb_dst == id_rt) ? wb_val : rf[id_rt];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    else if (wb_we) rf[memwb_dst] <= wb_val;

  // execute
  logic [31:0] ex_b, ex_alu, ex_tgt;
  logic [4:0]  ex_dst;
  assign ex_b   = idex_c[C_ALUSRC] ? idex_imm : idex_b;
  assign ex_dst = idex_c[C_REGDST] ? idex_rd : idex_rt;
  assign ex_tgt = idex_pc4 + {idex_imm[29:0], 2'b00};

  always_comb begin
    case (idex_c[7:6])
      2'b00: ex_alu = idex_a + ex_b;
      2'b01: ex_alu = idex_a - ex_b;
      default:
        case (idex_fn)
          FN_ADD:  ex_alu = idex_a + ex_b;
          FN_SUB:  ex_alu = idex_a - ex_b;
          FN_AND:  ex_alu = idex_a & ex_b;
          FN_OR:   ex_alu = idex_a | ex_b;
          FN_SLT:  ex_alu = ($signed(idex_a) < $signed(ex_b)) ? 32'd1 : 32'd0;
          default: ex_alu = 32'd0;
        endcase
    endcase
  end

  // memory
  logic        taken;
  logic [31:0] mem_rd;
  assign taken  = exmem_c[C_BR] && exmem_zero;
  assign mem_rd = dmem[exmem_alu[DMEM_AW+1:2]];

  always_ff @(posedge clk)
    if (data_we) dmem[data_addr] <= data_wdata;
    else if (exmem_c[C_MWR]) dmem[exmem_alu[DMEM_AW+1:2]] <= exmem_sd;

  // stage registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc <= '0; ifid_ir <= '0; ifid_pc4 <= '0;
    end else begin
      pc       <= taken ? exmem_tgt : pc + 32'd4;
      ifid_ir  <= taken ? 32'd0 : fetch_word;
      ifid_pc4 <= pc + 32'd4;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idex_c <= '0; idex_a <= '0; idex_b <= '0; idex_imm <= '0; idex_pc4 <= '0;
      idex_rt <= '0; idex_rd <= '0; idex_fn <= '0;
    end else begin
      idex_c   <= taken ? 9'd0 : id_c;
      idex_a   <= id_a;
      idex_b   <= id_b;
      idex_imm <= id_imm;
      idex_pc4 <= ifid_pc4;
      idex_rt  <= id_rt;
      idex_rd  <= id_rd;
      idex_fn  <= id_fn;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      exmem_c <= '0; exmem_zero <= 1'b0; exmem_tgt <= '0; exmem_alu <= '0;
      exmem_sd <= '0; exmem_dst <= '0;
      memwb_c <= '0; memwb_ld <= '0; memwb_alu <= '0; memwb_dst <= '0;
    end else begin
      exmem_c    <= taken ? 5'd0 : idex_c[4:0];
      exmem_zero <= (ex_alu == 32'd0);
      exmem_tgt  <= ex_tgt;
      exmem_alu  <= ex_alu;
      exmem_sd   <= idex_b;
      exmem_dst  <= ex_dst;
      memwb_c    <= exmem_c[1:0];
      memwb_ld   <= mem_rd;
      memwb_alu  <= exmem_alu;
      memwb_dst  <= exmem_dst;
    end

  assign pc_o       = pc;
  assign retire_we  = wb_we;
  assign retire_reg = memwb_dst;
  assign retire_val = wb_val;
  assign store_we   = exmem_c[C_MWR];
  assign store_addr = exmem_alu;
  assign store_val  = exmem_sd;

  AST_FLUSH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (ifid_ir == 32'd0 && idex_c == 9'd0 && exmem_c == 5'd0)); // R5
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> pc == $past(pc) + 32'd4); // R9
  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == 32'd0); // R6
  AST_DEST_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_c[C_RW] && exmem_dst != 5'd0) |=> (retire_we && retire_reg == $past(exmem_dst))); // R8
  AST_ONE_MEM_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exmem_c[4:2])); // R2
  AST_LOAD_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_c[C_MRD] && exmem_dst != 5'd0) |=> retire_val == $past(mem_rd)); // R4
endmodule

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;
  localparam int IAW = 8, DAW = 8;
  localparam int IW = 1 << IAW, DW = 1 << DAW;
  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hffff};

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_we = 1'b0, data_we = 1'b0;
  logic [IAW-1:0] prog_addr = '0;
  logic [DAW-1:0] data_addr = '0;
  logic [31:0] prog_data = '0, data_wdata = '0;
  logic [31:0] pc_o, retire_val, store_addr, store_val;
  logic retire_we, store_we;
  logic [4:0] retire_reg;

  always #2 clk = ~clk;

  pipe5_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) uut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .data_we(data_we), .data_addr(data_addr), .data_wdata(data_wdata), .pc_o(pc_o),
    .retire_we(retire_we), .retire_reg(retire_reg), .retire_val(retire_val),
    .store_we(store_we), .store_addr(store_addr), .store_val(store_val));

  int checks = 0, fails = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [31:0] prog [IW];
  logic [31:0] mdata [DW];
  logic [31:0] mreg [32];
  logic [36:0] exp_wb [$];
  string       exp_wb_tag [$];
  logic [63:0] exp_st [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] alu_ref(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  // instruction-level reference model: fills the expected retire and store streams
  task automatic model_run();
    logic [31:0] pc = 32'd0;
    bit after_br = 1'b0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    for (int s = 0; s < 4000; s++) begin
      logic [31:0] w, imm, addr, res;
      logic [5:0] op, fn;
      int rs, rt, rd;
      w = prog[pc[IAW+1:2]];
      if (w == HALT) break;
      op = w[31:26]; fn = w[5:0];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      imm = {{16{w[15]}}, w[15:0]};
      case (op)
        6'h00: if (fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2a}) begin
          res = alu_ref(fn, mreg[rs], mreg[rt]);
          if (rd != 0) begin
            exp_wb.push_back({5'(rd), res});
            exp_wb_tag.push_back(after_br ? "R2 R3 R7 R8 R5" : "R2 R3 R7 R8");
            mreg[rd] = res;
          end
        end
        6'h23: begin
          addr = mreg[rs] + imm;
          res = mdata[addr[DAW+1:2]];
          if (rt != 0) begin
            exp_wb.push_back({5'(rt), res});
            exp_wb_tag.push_back(after_br ? "R4 R8 R5" : "R4 R8");
            mreg[rt] = res;
          end
        end
        6'h2b: begin
          addr = mreg[rs] + imm;
          exp_st.push_back({addr, mreg[rt]});
          mdata[addr[DAW+1:2]] = mreg[rt];
        end
        6'h04: if (mreg[rs] == mreg[rt]) begin
          pc = pc + 32'd4 + {imm[29:0], 2'b00};
          after_br = 1'b1;
          continue;
        end
        default: ;
      endcase
      pc = pc + 32'd4;
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (retire_we) begin
      if (exp_wb.size() == 0) chk(1'b0, "R10 R5 unexpected retire", {27'd0, retire_reg}, 32'd0);
      else begin
        logic [36:0] e;
        string t;
        e = exp_wb.pop_front();
        t = exp_wb_tag.pop_front();
        chk(retire_reg == e[36:32], {t, " retire register"}, {27'd0, retire_reg}, {27'd0, e[36:32]});
        chk(retire_val == e[31:0], {t, " retire value"}, retire_val, e[31:0]);
      end
    end
    if (store_we) begin
      if (exp_st.size() == 0) chk(1'b0, "R10 R5 unexpected store", store_addr, 32'd0);
      else begin
        logic [63:0] e;
        e = exp_st.pop_front();
        chk(store_addr == e[63:32], "R4 store address", store_addr, e[63:32]);
        chk(store_val == e[31:0], "R4 store data", store_val, e[31:0]);
      end
    end
  end

  task automatic load_and_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk(pc_o == 32'd0 && !retire_we && !store_we, "R1 reset state", pc_o, 32'd0);
    for (int i = 0; i < IW; i++) begin
      prog_we = 1'b1; prog_addr = IAW'(i); prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    for (int i = 0; i < DW; i++) begin
      data_we = 1'b1; data_addr = DAW'(i); data_wdata = mdata[i];
      @(negedge clk);
    end
    data_we = 1'b0;
    model_run();
  endtask

  task automatic finish_prog(input int cycles);
    repeat (cycles) @(negedge clk);
    mon_on = 1'b0;
    chk(exp_wb.size() == 0, "R5 R10 retires still pending", exp_wb.size(), 32'd0);
    chk(exp_st.size() == 0, "R4 stores still pending", exp_st.size(), 32'd0);
    exp_wb.delete(); exp_wb_tag.delete(); exp_st.delete();
  endtask

  task automatic gen_prog(input int n);
    int w = 0, halt_w;
    for (int i = 0; i < IW; i++) prog[i] = 32'd0;
    for (int i = 0; i < DW; i++) mdata[i] = $urandom();
    halt_w = 3 * (4 + n);
    for (int r = 1; r <= 4; r++) begin
      prog[w] = enc_i(6'h23, 0, r, 4 * int'($urandom_range(0, DW - 1)));
      w += 3;
    end
    for (int i = 0; i < n; i++) begin
      int k = int'($urandom_range(0, 9));
      int a = int'($urandom_range(0, 7)), b = int'($urandom_range(0, 7)), d = int'($urandom_range(0, 7));
      logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2a};
      if (k <= 4) prog[w] = enc_r(a, b, d, fns[$urandom_range(0, 4)]);
      else if (k <= 6) prog[w] = enc_i(6'h23, a, d, int'($urandom_range(0, 4095)) - 2048);
      else if (k == 7) prog[w] = enc_i(6'h2b, a, b, int'($urandom_range(0, 4095)) - 2048);
      else if (k == 8) begin
        if ($urandom_range(0, 2) == 0) a = 0;
        if ($urandom_range(0, 2) == 0) b = a;
        prog[w] = enc_i(6'h04, a, b, int'($urandom_range(1, halt_w - w - 1)));
      end else prog[w] = ($urandom_range(0, 1) == 0) ? {6'h3f, 26'($urandom())} : enc_r(a, b, d, 6'h07);
      w += 3;
    end
    prog[halt_w] = HALT;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      report();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // directed: back-to-back independent loads, r0 write, unused encodings
    for (int i = 0; i < IW; i++) prog[i] = 32'd0;
    for (int i = 0; i < DW; i++) mdata[i] = 32'h1000_0000 + 32'(i * 7);
    for (int i = 0; i < 8; i++) prog[i] = enc_i(6'h23, 0, i + 1, 4 * (i + 3));
    prog[10] = enc_r(1, 2, 0, 6'h20);
    prog[11] = {6'h3f, 26'h3ffffff};
    prog[12] = enc_r(3, 4, 5, 6'h3f);
    prog[13] = enc_r(0, 3, 9, 6'h25);
    prog[14] = enc_i(6'h2b, 0, 0, 8);
    prog[17] = HALT;
    load_and_reset();
    rst_n = 1'b1;
    mon_on = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k < 4) chk(!retire_we, "R1 no retire before fourth edge", {31'd0, retire_we}, 32'd0);
      else if (k <= 11) chk(retire_we && retire_reg == 5'(k - 3), "R9 R11 consecutive load retire",
                            {27'd0, retire_reg}, 32'(k - 3));
    end
    finish_prog(60);
    chk(store_we == 1'b0, "R6 R10 quiet after program", {31'd0, store_we}, 32'd0);

    for (int p = 0; p < 8; p++) begin
      gen_prog(20);
      load_and_reset();
      rst_n = 1'b1;
      mon_on = 1'b1;
      finish_prog(300);
    end
    done = 1'b1;
    report();
  end
endmodule